// File: doc/BRIEF.md
# Fractional MAC Rounding Unit

This block sits behind the multiplier and the accumulator of a multiply-accumulate datapath. It takes one operand word per cycle, qualified by a valid bit, and reduces it to a narrower result. Two paths share the stage. The product path takes a 64-bit product of two 32-bit operands and keeps its upper 40 bits. The store path takes a 48-bit accumulator and produces either a 32-bit or a 16-bit value, sign- or zero-extended to the 40-bit result bus.

Three mode bits decide whether the discarded bits are used. `mode_fi` selects fractional (1) or integer (0) data. `mode_su` selects signed (0) or unsigned (1) data, and in fractional mode it also selects the store width. `mode_rt` selects rounding (1) or truncation (0). Rounding is always round-to-nearest-even. When a round-up would carry past the most positive kept value, the result saturates to that value and the overflow flag is raised. The result, the flag and the valid bit appear one clock after the input.

Top module: `frac_round_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. While `rst` is high at a rising edge, `out_valid` and `out_ovf` are cleared at that edge.
- R2: With `path_store`=0, `mode_fi`=1 and `mode_rt`=1, the result is operand[63:24] rounded to nearest even, using operand[23:0] as the discarded field.
- R3: With `path_store`=0 and either `mode_fi`=0 or `mode_rt`=0, the result is operand[63:24] unchanged and `out_ovf` is 0.
- R4: With `path_store`=1, `mode_fi`=1, `mode_su`=0 and `mode_rt`=1, the result is operand[39:8] rounded using operand[7:0], then sign-extended to 40 bits.
- R5: With `path_store`=1, `mode_fi`=1, `mode_su`=0 and `mode_rt`=0, the result is operand[39:8] sign-extended to 40 bits and `out_ovf` is 0.
- R6: With `path_store`=1, `mode_fi`=1 and `mode_su`=1, the result is operand[39:24] rounded using operand[23:0], then sign-extended to 40 bits, whatever the value of `mode_rt`.
- R7: With `path_store`=1 and `mode_fi`=0, the result is operand[31:0]. It is sign-extended when `mode_su`=0 and zero-extended when `mode_su`=1. It is never rounded, and `out_ovf` is 0.
- R8: A discarded field below half truncates and one above half increments. A field exactly equal to half (MSB 1, rest 0) increments only when the kept LSB is 1, so the result LSB is 0.
- R9: When rounding would increment the most positive kept value (0 followed by all ones), the kept field saturates to that value and `out_ovf` is 1. Otherwise `out_ovf` is 0.
- R10: On the store path, operand[63:40] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand valid |
| path_store | input | 1 | 0 selects the product path, 1 selects the accumulator-store path |
| mode_su | input | 1 | 0 signed, 1 unsigned; in fractional mode also picks the 32-bit (0) or 16-bit (1) store |
| mode_fi | input | 1 | 1 fractional, 0 integer |
| mode_rt | input | 1 | 1 round, 0 truncate |
| operand | input | 64 | Product (all 64 bits) or accumulator (bits 47:0) |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 40 | Rounded or truncated result, extended to 40 bits |
| out_ovf | output | 1 | A round-up saturated the result |

## Verification
The assertions check the following on every clock:
- the one-cycle valid delay and the reset clear;
- that every raised overflow flag comes with a positive-maximum result;
- that the product path passes through unchanged when rounding is off;
- that a tie with an even kept LSB never increments, in each of the three rounders.

The bench sweeps both paths across all eight mode combinations. For each, it uses kept values of both parities, the positive maximum and a negative value, against discarded fields below, at and above half and all ones. Only these scenarios can show that the right rounder and the right width are picked for each mode, that the integer store extends correctly, and that the bits above the accumulator field are ignored.

// File: rtl/frac_round_pkg.sv
package frac_round_pkg;

  typedef enum logic {
    PATH_PRODUCT = 1'b0,
    PATH_STORE   = 1'b1
  } path_e;

  // Round-to-nearest-even increment decision
  function automatic logic rne_take_up(input logic above_half,
                                       input logic at_half,
                                       input logic kept_lsb);
    return above_half | (at_half & kept_lsb);
  endfunction

endpackage

// File: rtl/rne_stage.sv
module rne_stage
  import frac_round_pkg::*;
#(
  parameter int KW = 40,
  parameter int DW = 24
) (
  input  logic [KW-1:0] kept,
  input  logic [DW-1:0] disc,
  input  logic          rnd_en,
  output logic [KW-1:0] rounded,
  output logic          carry_sat,
  output logic          inc,
  output logic          tie
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};
  localparam logic [KW-1:0] KMAX = {1'b0, {(KW-1){1'b1}}};

  logic above;

  always_comb begin
    above     = disc > HALF;
    tie       = disc == HALF;
    inc       = rnd_en & rne_take_up(above, tie, kept[0]);
    carry_sat = inc & (kept == KMAX);
    rounded   = carry_sat ? KMAX : kept + {{(KW-1){1'b0}}, inc};
  end
endmodule

// File: rtl/round_mode_dec.sv
module round_mode_dec (
  input  logic path_store,
  input  logic mode_su,
  input  logic mode_fi,
  input  logic mode_rt,
  output logic prod_rnd,
  output logic st32_rnd,
  output logic st16_sel,
  output logic int_store
);
  always_comb begin
    prod_rnd  = !path_store & mode_fi & mode_rt;
    int_store = path_store & !mode_fi;
    st16_sel  = path_store & mode_fi & mode_su;
    st32_rnd  = path_store & mode_fi & !mode_su & mode_rt;
  end
endmodule

// File: rtl/frac_round_unit.sv
module frac_round_unit
  import frac_round_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int ACC_W  = 48,
  parameter int EXT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    path_store,
  input  logic                    mode_su,
  input  logic                    mode_fi,
  input  logic                    mode_rt,
  input  logic [2*OPND_W-1:0]     operand,
  output logic                    out_valid,
  output logic [OPND_W+EXT_W-1:0] result,
  output logic                    out_ovf
);
  localparam int PROD_W  = 2 * OPND_W;
  localparam int RES_W   = OPND_W + EXT_W;
  localparam int P_DISC  = PROD_W - RES_W;
  localparam int S32_K   = OPND_W;
  localparam int S32_D   = ACC_W - EXT_W - S32_K;
  localparam int S16_K   = OPND_W / 2;
  localparam int S16_D   = ACC_W - EXT_W - S16_K;

  logic prod_rnd, st32_rnd, st16_sel, int_store;

  round_mode_dec u_dec (
    .path_store(path_store), .mode_su(mode_su), .mode_fi(mode_fi), .mode_rt(mode_rt),
    .prod_rnd(prod_rnd), .st32_rnd(st32_rnd), .st16_sel(st16_sel), .int_store(int_store)
  );

  // Named internal events for the checks
  logic [RES_W-1:0] prod_out;
  logic [S32_K-1:0] s32_out;
  logic [S16_K-1:0] s16_out;
  logic prod_sat, prod_inc, prod_tie;
  logic s32_sat, s32_inc, s32_tie;
  logic s16_sat, s16_inc, s16_tie;

  rne_stage #(.KW(RES_W), .DW(P_DISC)) u_prod (
    .kept(operand[PROD_W-1:P_DISC]), .disc(operand[P_DISC-1:0]), .rnd_en(prod_rnd),
    .rounded(prod_out), .carry_sat(prod_sat), .inc(prod_inc), .tie(prod_tie)
  );

  rne_stage #(.KW(S32_K), .DW(S32_D)) u_st32 (
    .kept(operand[S32_D+S32_K-1:S32_D]), .disc(operand[S32_D-1:0]), .rnd_en(st32_rnd),
    .rounded(s32_out), .carry_sat(s32_sat), .inc(s32_inc), .tie(s32_tie)
  );

  rne_stage #(.KW(S16_K), .DW(S16_D)) u_st16 (
    .kept(operand[S16_D+S16_K-1:S16_D]), .disc(operand[S16_D-1:0]), .rnd_en(st16_sel),
    .rounded(s16_out), .carry_sat(s16_sat), .inc(s16_inc), .tie(s16_tie)
  );

  logic [RES_W-1:0] nxt_res;
  logic             nxt_ovf;
  path_e            path;

  always_comb begin
    path = path_e'(path_store);
    if (path == PATH_PRODUCT) begin
      nxt_res = prod_out;
      nxt_ovf = prod_sat;
    end else if (int_store) begin
      nxt_res = mode_su ? {{(RES_W-OPND_W){1'b0}}, operand[OPND_W-1:0]}
                        : {{(RES_W-OPND_W){operand[OPND_W-1]}}, operand[OPND_W-1:0]};
      nxt_ovf = 1'b0;
    end else if (st16_sel) begin
      nxt_res = {{(RES_W-S16_K){s16_out[S16_K-1]}}, s16_out};
      nxt_ovf = s16_sat;
    end else begin
      nxt_res = {{(RES_W-S32_K){s32_out[S32_K-1]}}, s32_out};
      nxt_ovf = s32_sat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      out_ovf   <= nxt_ovf;
      result    <= nxt_res;
    end
  end

  // ---------------- assertions ----------------
  localparam logic [RES_W-1:0] MAX40 = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX32 = {{(RES_W-S32_K+1){1'b0}}, {(S32_K-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX16 = {{(RES_W-S16_K+1){1'b0}}, {(S16_K-1){1'b1}}};

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf));
  assert_sat_max_R9: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (result == MAX40 || result == MAX32 || result == MAX16));
  assert_prod_trunc_R3: assert property (@(posedge clk) disable iff (rst)
    !prod_rnd |-> (prod_out == operand[PROD_W-1:P_DISC] && !prod_sat));
  assert_tie_even_prod_R8: assert property (@(posedge clk) disable iff (rst)
    (prod_tie && !operand[P_DISC]) |-> !prod_inc);
  assert_tie_even_s32_R8: assert property (@(posedge clk) disable iff (rst)
    (s32_tie && !operand[S32_D]) |-> !s32_inc);
  assert_tie_even_s16_R8: assert property (@(posedge clk) disable iff (rst)
    (s16_tie && !operand[S16_D]) |-> !s16_inc);
endmodule

// File: tb/tb_frac_round_unit.sv
`timescale 1ns/1ps
module tb_frac_round_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic path_store = 1'b0, mode_su = 1'b0, mode_fi = 1'b0, mode_rt = 1'b0;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [39:0] result;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  frac_round_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .path_store(path_store),
    .mode_su(mode_su), .mode_fi(mode_fi), .mode_rt(mode_rt), .operand(operand),
    .out_valid(out_valid), .result(result), .out_ovf(out_ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned msk(input int w);
    return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic longint unsigned sx40(input longint unsigned v, input int w);
    longint unsigned r;
    r = v & msk(w);
    if (r[w-1]) r = r | ~msk(w);
    return r & msk(40);
  endfunction

  // Reference rounding model: arithmetic on whole numbers
  function automatic longint unsigned ref_round(input longint unsigned k, input longint unsigned d,
                                                input int kw, input int dw, input bit en,
                                                output bit ovf);
    longint unsigned half, kmax;
    bit up;
    half = 64'd1 << (dw - 1);
    kmax = (64'd1 << (kw - 1)) - 64'd1;
    up = en && ((d > half) || (d == half && k[0]));
    ovf = 1'b0;
    if (up && k == kmax) begin
      ovf = 1'b1;
      return kmax;
    end
    return (k + (up ? 64'd1 : 64'd0)) & msk(kw);
  endfunction

  task automatic apply(input bit v, input bit ps, input bit su, input bit fi, input bit rt,
                       input logic [63:0] op);
    @(negedge clk);
    in_valid = v; path_store = ps; mode_su = su; mode_fi = fi; mode_rt = rt; operand = op;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned k, d, op, exp, half, kmax;
    bit eovf, en;
    int kw, dw;
    string tag;
    logic [39:0] r_first;

    // R1: reset state
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_ovf == 1'b0, "R1 reset ovf", out_ovf, 0);
    rst = 1'b0;
    in_valid = 1'b0;

    // Sweep: 2 paths x 8 modes x 4 kept values x 4 discarded fields
    for (int ps = 0; ps < 2; ps++) begin
      for (int m = 0; m < 8; m++) begin
        for (int ki = 0; ki < 4; ki++) begin
          for (int di = 0; di < 4; di++) begin
            bit su, fi, rt;
            su = m[2]; fi = m[1]; rt = m[0];
            if (ps == 0) begin kw = 40; dw = 24; end
            else if (su) begin kw = 16; dw = 24; end
            else begin kw = 32; dw = 8; end
            half = 64'd1 << (dw - 1);
            kmax = (64'd1 << (kw - 1)) - 64'd1;
            case (ki)
              0: k = kmax - 64'd1;
              1: k = kmax;
              2: k = msk(kw) - 64'd2;
              default: k = 64'd42;
            endcase
            case (di)
              0: d = half - 64'd1;
              1: d = half;
              2: d = half + 64'd1;
              default: d = msk(dw);
            endcase
            if (ps == 0) op = (k << dw) | d;
            else op = (64'h3C5A << 48) | (64'hA5 << 40) | (k << dw) | d;

            if (ps == 1 && !fi) begin
              exp = su ? (op & msk(32)) : sx40(op, 32);
              eovf = 1'b0;
              tag = "R7";
            end else begin
              if (ps == 0) begin en = fi && rt; tag = en ? "R2" : "R3"; end
              else if (su) begin en = 1'b1; tag = "R6"; end
              else begin en = rt; tag = rt ? "R4" : "R5"; end
              exp = sx40(ref_round(k, d, kw, dw, en, eovf), kw);
              if (en && d == half) tag = {tag, " R8 tie"};
            end
            apply(1'b1, ps[0], su, fi, rt, op);
            chk(result == exp[39:0], tag, result, exp);
            chk(out_ovf == eovf, "R9 ovf", out_ovf, eovf);
            chk(out_valid == 1'b1, "R1 valid", out_valid, 1);
          end
        end
      end
    end

    // R10: upper operand bits do not affect the store path
    for (int j = 0; j < 3; j++) begin
      apply(1'b1, 1'b1, j[0], 1'b1, 1'b1, 64'h0000_0012_3456_7880);
      r_first = result;
      apply(1'b1, 1'b1, j[0], 1'b1, 1'b1, 64'hFFFF_FF12_3456_7880);
      chk(result == r_first, "R10 high bits", result, r_first);
    end

    // R1: a bubble drops out_valid
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h1);
    chk(out_valid == 1'b0, "R1 bubble", out_valid, 0);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h1);
    chk(out_valid == 1'b1, "R1 resume", out_valid, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule